// File: doc/BRIEF.md
# T1 Framing Error Injector

This block sits in a T1 transmit path. It corrupts selected overhead bits on request, so that the error detection of a far-end framer can be tested. The serial stream enters one bit per valid strobe. Each bit carries tags from an upstream frame counter: the frame-number parity, an F-bit marker, CRC and DDS pattern markers with a pattern-first flag, and a synchronization marker. The block leaves the stream with a fixed latency of one clock.

Four request bits sit in a small register. Software arms a request by writing a 1 into a bit that holds 0. The request then waits for the first overhead element that is eligible under the current framing format. It inverts that element once and then clears its own bit. A framing-disable input holds every request off.

Format codes on `fmt_sel`: 2'b00 superframe (SF), 2'b01 extended superframe (ESF), 2'b10 T1 DM, 2'b11 SLC-96.

Top module: `t1_err_inject`

## Requirements
- R1: The register layout is DDS request at bit 3, CRC request at bit 2, Fs request at bit 1 and Ft request at bit 0. Bits 7..4 always read 0. After reset, all bits read 0, and `bit_out` and `vld_out` are 0.
- R2: A request is armed only by writing 1 into a bit that reads 0. Writing 1 into a bit that already reads 1 adds no second inversion. Writing 0 cancels a pending request. No bit is ever inverted while no request bit reads 1.
- R3: A request bit clears itself once its single inversion is complete. The bit reads 0 from the cycle in which the last inverted bit appears at `bit_out`.
- R4: While `fdis_in` is 1, no bit is inverted and pending requests stay set.
- R5: Ft request, in SF, DM and SLC-96 only: inverts the first F-bit (`fbit_tag`=1) with `frm_odd`=1 after arming.
- R6: Fs request. In SF and DM it inverts the first F-bit with `frm_odd`=0. In ESF and SLC-96 it inverts the first F-bit that has `sync_tag`=1.
- R7: CRC request, in ESF only. It inverts the six consecutive `crc_tag` bits of one pattern. The pattern starts at a bit with `pat_first`=1. If the request is armed mid-pattern, that pattern's remaining bits pass unchanged.
- R8: DDS request, in DM only. It inverts the six `dds_tag` bits of one whole pattern, starting at `pat_first`, with the same mid-pattern rule as R7.
- R9: A request written while its format is not selected stays pending and changes no bit.
- R10: `bit_out` is `bit_in` (possibly inverted) one clock later, and `vld_out` is `bit_vld` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Transmit bit |
| bit_vld | input | 1 | Transmit bit valid |
| frm_odd | input | 1 | Parity of current frame number (1 = odd) |
| fbit_tag | input | 1 | Current bit is the frame F-bit |
| crc_tag | input | 1 | Current bit belongs to a CRC pattern |
| dds_tag | input | 1 | Current bit belongs to a DDS pattern |
| sync_tag | input | 1 | Current F-bit is a frame-alignment / sync bit |
| pat_first | input | 1 | First bit of a 6-bit CRC or DDS pattern |
| fmt_sel | input | 2 | Framing format code |
| fdis_in | input | 1 | Framing disable; holds all requests off |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register readback |
| bit_out | output | 1 | Transmit bit after injection |
| vld_out | output | 1 | Delayed valid |

## Verification
Frames alternate odd and even F-bits, so each test shows whether the Ft and Fs requests pick the correct parity and stop after one hit. In ESF and SLC-96, F-bits with and without the sync marker tell the sync-tag rule apart from the parity rule. CRC and DDS patterns come as a partial pattern, then a full pattern, then a second full pattern. This shows that inversion waits for the pattern start, covers all six bits, and stops. Each request is also written under a format where it does not apply, and again with framing disabled, to show that it stays pending and changes nothing.

// File: rtl/t1ei_pkg.sv
// Shared types for the T1 framing error injector.
// Assumes request bit indices are fixed by the register layout.
package t1ei_pkg;
    typedef enum logic [1:0] {
        FMT_SF  = 2'b00,
        FMT_ESF = 2'b01,
        FMT_DM  = 2'b10,
        FMT_SLC = 2'b11
    } fmt_e;

    localparam int REQ_FT    = 0;
    localparam int REQ_FS    = 1;
    localparam int REQ_CRC   = 2;
    localparam int REQ_DDS   = 3;
    localparam int REQ_COUNT = 4;
endpackage

// File: rtl/t1ei_req_reg.sv
// Request register: holds one pending bit per request type.
// A write loads the request bits directly, so only a 0-to-1 change arms a request.
// A done pulse clears its bit. Assumes REG_W > NREQ.
module t1ei_req_reg #(
    parameter int REG_W = 8,
    parameter int NREQ  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic [NREQ-1:0]  done,
    output logic [NREQ-1:0]  pend,
    output logic [REG_W-1:0] rdata
);
    localparam int RSV_W = REG_W - NREQ;

    // Hold pending requests: a write takes priority, otherwise completed requests clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (wr) begin
            pend <= wdata[NREQ-1:0];
        end else begin
            pend <= pend & ~done;
        end
    end

    // Readback: reserved bits read as zero
    always_comb begin
        rdata = {{RSV_W{1'b0}}, pend};
    end

    logic unused_wdata;
    assign unused_wdata = ^wdata[REG_W-1:NREQ];
endmodule

// File: rtl/t1ei_elig.sv
// Eligibility decode: for each request type, flags whether the current bit
// is an element that the request may invert under the selected format.
// Assumes the upstream tags are mutually consistent for the format.
module t1ei_elig
    import t1ei_pkg::*;
(
    input  logic                 vld,
    input  logic                 fdis,
    input  fmt_e                 fmt,
    input  logic                 odd,
    input  logic                 fbit,
    input  logic                 crc,
    input  logic                 dds,
    input  logic                 sync,
    output logic [REQ_COUNT-1:0] elig
);
    logic en;
    logic parity_fs;

    // Per-type eligibility; everything gated by valid and framing-disable
    always_comb begin
        en        = vld & ~fdis;
        parity_fs = (fmt == FMT_SF) || (fmt == FMT_DM);
        elig                = '0;
        elig[REQ_FT]        = en & fbit & odd & (fmt != FMT_ESF);
        elig[REQ_FS]        = en & fbit & (parity_fs ? ~odd : sync);
        elig[REQ_CRC]       = en & crc & (fmt == FMT_ESF);
        elig[REQ_DDS]       = en & dds & (fmt == FMT_DM);
    end
endmodule

// File: rtl/t1ei_inv_unit.sv
// Inversion sequencer for one request type. It inverts PAT_LEN consecutive
// eligible bits, starting at a bit flagged 'first'. A single-bit element
// uses PAT_LEN=1 with 'first' tied high. Dropping 'pend' aborts a run.
module t1ei_inv_unit #(
    parameter int PAT_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    input  logic elig,
    input  logic first,
    output logic flip,
    output logic done
);
    localparam int CNT_W = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PAT_LEN - 1);

    logic             active;
    logic [CNT_W-1:0] cnt;

    // Invert when pending and either mid-run or at a pattern start
    always_comb begin
        flip = pend & elig & (active | first);
        done = flip & (cnt == LAST);
    end

    // Track progress through the pattern being inverted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (!pend || done) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (flip) begin
            active <= 1'b1;
            cnt    <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/t1_err_inject.sv
// T1 framing error injector top. Combines the request register, the
// eligibility decode, one inversion sequencer per request type and a
// one-clock output register. Assumes upstream tags are aligned with bit_in.
module t1_err_inject
    import t1ei_pkg::*;
#(
    parameter int REG_W   = 8,
    parameter int PAT_LEN = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             bit_vld,
    input  logic             frm_odd,
    input  logic             fbit_tag,
    input  logic             crc_tag,
    input  logic             dds_tag,
    input  logic             sync_tag,
    input  logic             pat_first,
    input  logic [1:0]       fmt_sel,
    input  logic             fdis_in,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             bit_out,
    output logic             vld_out
);
    localparam int NREQ = REQ_COUNT;

    fmt_e            fmt;
    logic [NREQ-1:0] pend;
    logic [NREQ-1:0] elig;
    logic [NREQ-1:0] flip;
    logic [NREQ-1:0] done;

    assign fmt = fmt_e'(fmt_sel);

    t1ei_req_reg #(.REG_W(REG_W), .NREQ(NREQ)) u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .done  (done),
        .pend  (pend),
        .rdata (reg_rdata)
    );

    t1ei_elig u_elig (
        .vld  (bit_vld),
        .fdis (fdis_in),
        .fmt  (fmt),
        .odd  (frm_odd),
        .fbit (fbit_tag),
        .crc  (crc_tag),
        .dds  (dds_tag),
        .sync (sync_tag),
        .elig (elig)
    );

    // One sequencer per request; pattern types get PAT_LEN, single bits get 1
    for (genvar gi = 0; gi < NREQ; gi++) begin : g_unit
        localparam bit IS_PAT = (gi == REQ_CRC) || (gi == REQ_DDS);
        localparam int LEN    = IS_PAT ? PAT_LEN : 1;
        logic first_w;
        if (IS_PAT) begin : g_pat
            assign first_w = pat_first;
        end else begin : g_single
            assign first_w = 1'b1;
        end
        t1ei_inv_unit #(.PAT_LEN(LEN)) u_unit (
            .clk   (clk),
            .rst_n (rst_n),
            .pend  (pend[gi]),
            .elig  (elig[gi]),
            .first (first_w),
            .flip  (flip[gi]),
            .done  (done[gi])
        );
    end

    // Output stage: apply any inversion and delay valid by one clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_out <= 1'b0;
            vld_out <= 1'b0;
        end else begin
            bit_out <= bit_in ^ (|flip);
            vld_out <= bit_vld;
        end
    end
endmodule

// File: rtl/t1ei_chk.sv
// Port-level checker for the T1 framing error injector, attached by bind.
module t1ei_chk #(
    parameter int REG_W = 8,
    parameter int NREQ  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_in,
    input logic             bit_vld,
    input logic             fdis_in,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_rdata,
    input logic             bit_out,
    input logic             vld_out
);
    // R1
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:NREQ] == '0);

    // R2
    no_self_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ((reg_rdata[NREQ-1:0] & ~$past(reg_rdata[NREQ-1:0])) == '0));

    // R2
    no_flip_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> ((bit_out == $past(bit_in)) || ($past(reg_rdata[NREQ-1:0]) != '0)));

    // R3
    clear_with_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ((($past(reg_rdata[NREQ-1:0]) & ~reg_rdata[NREQ-1:0]) == '0)
                     || (bit_out != $past(bit_in))));

    // R4
    fdis_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fdis_in && bit_vld) |=> (bit_out == $past(bit_in)));

    // R10
    vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> vld_out);

    // R10
    vld_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> !vld_out);
endmodule

bind t1_err_inject t1ei_chk #(.REG_W(REG_W), .NREQ(NREQ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_in    (bit_in),
    .bit_vld   (bit_vld),
    .fdis_in   (fdis_in),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .bit_out   (bit_out),
    .vld_out   (vld_out)
);

// File: tb/test_t1_err_inject.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue the expected output bit for each
// input bit; a monitor pops and compares at every valid output.
module test_t1_err_inject;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0, bit_vld = 1'b0, frm_odd = 1'b0, fbit_tag = 1'b0;
    logic       crc_tag = 1'b0, dds_tag = 1'b0, sync_tag = 1'b0, pat_first = 1'b0;
    logic [1:0] fmt_sel = 2'b00;
    logic       fdis_in = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       bit_out, vld_out;

    int n_cmp = 0;
    int n_bad = 0;
    logic  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    t1_err_inject i_t1_err_inject (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .frm_odd(frm_odd), .fbit_tag(fbit_tag), .crc_tag(crc_tag),
        .dds_tag(dds_tag), .sync_tag(sync_tag), .pat_first(pat_first),
        .fmt_sel(fmt_sel), .fdis_in(fdis_in), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bit_out(bit_out), .vld_out(vld_out)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare every valid output bit against the queue head
    always @(negedge clk) begin
        if (rst_n && vld_out) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R10: actual unexpected bit %b expected none", bit_out);
            end else begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({7'b0, bit_out}, {7'b0, e}, t);
            end
        end
    end

    // Drive one valid bit with its tags and queue the expected result
    task automatic put(input logic b, input logic f, input logic odd, input logic crc,
                       input logic dds, input logic sync, input logic first,
                       input logic flip, input string tag);
        bit_in = b; fbit_tag = f; frm_odd = odd; crc_tag = crc; dds_tag = dds;
        sync_tag = sync; pat_first = first; bit_vld = 1'b1;
        exp_q.push_back(b ^ flip);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        bit_vld = 1'b0; fbit_tag = 1'b0; crc_tag = 1'b0; dds_tag = 1'b0;
        sync_tag = 1'b0; pat_first = 1'b0;
    endtask

    // One short frame: F-bit followed by three untagged payload bits
    task automatic frame(input logic odd, input logic sync, input logic flip, input string tag);
        put(1'($urandom_range(0, 1)), 1'b1, odd, 1'b0, 1'b0, sync, 1'b0, flip, tag);
        for (int k = 0; k < 3; k++)
            put(1'($urandom_range(0, 1)), 1'b0, odd, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    // CRC or DDS pattern bits from index 'from' to 5
    task automatic pat(input logic is_crc, input int from, input logic flip, input string tag);
        for (int k = from; k < 6; k++)
            put(1'($urandom_range(0, 1)), 1'b0, 1'b0, is_crc, ~is_crc, 1'b0, k == 0, flip, tag);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic drain();
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        // R1 reset state
        check(reg_rdata, 8'h00, "R1 reset readback");
        check({6'b0, bit_out, vld_out}, 8'h00, "R1 reset outputs");
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R5 Ft in SF: first odd F-bit after arming
        fmt_sel = 2'b00;
        wr(8'hF1);
        check(reg_rdata, 8'h01, "R1 reserved bits read zero");
        frame(0, 0, 0, "R5"); frame(1, 0, 1, "R5"); frame(0, 0, 0, "R5"); frame(1, 0, 0, "R5");
        drain();
        check(reg_rdata, 8'h00, "R3 Ft self-clear");

        // R6 Fs in SF: first even F-bit
        wr(8'h02);
        frame(1, 0, 0, "R6"); frame(0, 0, 1, "R6"); frame(1, 0, 0, "R6"); frame(0, 0, 0, "R6");
        drain();
        check(reg_rdata, 8'h00, "R3 Fs self-clear");

        // R4 framing disable holds the request
        fdis_in = 1'b1;
        wr(8'h01);
        frame(1, 0, 0, "R4"); frame(0, 0, 0, "R4"); frame(1, 0, 0, "R4");
        drain();
        check(reg_rdata, 8'h01, "R4 request stays pending");
        // R2 writing 1 over 1 adds nothing
        wr(8'h01);
        fdis_in = 1'b0;
        frame(1, 0, 1, "R2"); frame(0, 0, 0, "R2"); frame(1, 0, 0, "R2"); frame(1, 0, 0, "R2");
        drain();
        check(reg_rdata, 8'h00, "R2 single inversion");
        // R2 cancel
        wr(8'h01); wr(8'h00);
        frame(1, 0, 0, "R2 cancel");
        drain();
        check(reg_rdata, 8'h00, "R2 cancelled");

        // R7 R9 ESF
        fmt_sel = 2'b01;
        wr(8'h01);
        frame(1, 0, 0, "R9"); frame(0, 0, 0, "R9"); frame(1, 1, 0, "R9");
        drain();
        check(reg_rdata, 8'h01, "R9 Ft pending in ESF");
        wr(8'h00);
        wr(8'h02);
        frame(1, 0, 0, "R6 ESF"); frame(0, 0, 0, "R6 ESF"); frame(1, 1, 1, "R6 ESF"); frame(0, 1, 0, "R6 ESF");
        drain();
        check(reg_rdata, 8'h00, "R6 ESF self-clear");
        wr(8'h04);
        pat(1, 3, 0, "R7 partial"); pat(1, 0, 1, "R7 full"); pat(1, 0, 0, "R7 after");
        drain();
        check(reg_rdata, 8'h00, "R7 self-clear");
        wr(8'h08);
        pat(0, 0, 0, "R9 DDS in ESF");
        drain();
        check(reg_rdata, 8'h08, "R9 DDS pending in ESF");
        wr(8'h00);

        // R8 DM
        fmt_sel = 2'b10;
        wr(8'h08);
        pat(0, 2, 0, "R8 partial"); pat(0, 0, 1, "R8 full"); pat(0, 0, 0, "R8 after");
        drain();
        check(reg_rdata, 8'h00, "R8 self-clear");
        wr(8'h04);
        pat(1, 0, 0, "R9 CRC in DM");
        drain();
        check(reg_rdata, 8'h04, "R9 CRC pending in DM");
        wr(8'h00);
        wr(8'h02);
        frame(1, 0, 0, "R6 DM"); frame(0, 0, 1, "R6 DM");
        drain();
        check(reg_rdata, 8'h00, "R6 DM self-clear");

        // R6 R5 SLC-96
        fmt_sel = 2'b11;
        wr(8'h02);
        frame(0, 0, 0, "R6 SLC"); frame(1, 0, 0, "R6 SLC"); frame(0, 1, 1, "R6 SLC");
        wr(8'h01);
        frame(0, 1, 0, "R5 SLC"); frame(1, 0, 1, "R5 SLC");
        drain();
        check(reg_rdata, 8'h00, "R5 SLC self-clear");

        // Both F-bit requests together in SF
        fmt_sel = 2'b00;
        wr(8'h03);
        frame(1, 0, 1, "R5 joint"); frame(0, 0, 1, "R6 joint"); frame(1, 0, 0, "R5 joint");
        drain();
        check(reg_rdata, 8'h00, "R3 joint self-clear");

        // R10 latency
        put(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
        check({7'b0, vld_out}, 8'h01, "R10 valid one clock later");
        @(posedge clk); #1;
        check({7'b0, vld_out}, 8'h00, "R10 valid drops");
        drain();
        check(8'(exp_q.size()), 8'h00, "R10 all bits delivered");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule